// File: doc/BRIEF.md
# Decimal Floating-Point Adder/Subtractor

This unit adds or subtracts two decimal floating-point numbers. Each number packs a sign bit for the fraction, a two-digit exponent stored with a bias of 50, and an eight-digit fraction. Every digit is held in excess-3 code. The fraction is a signed magnitude with its own sign bit, and its value is read as .d1d2...d8.

A pulse on `start` captures both operands and the operation. The unit then works in steps. First it equalizes the exponents. Each clock it moves the fraction with the smaller exponent one decimal digit to the right. Next it negates the aligned fractions into ten's complement where the effective sign calls for it, adds them in one step, and turns a negative sum back into a magnitude with a sign. Last it normalizes one digit per clock. When the result is ready, `done` pulses for one cycle. `overflow` or `underflow` pulses with it when the exponent leaves its range.

Top module: `dfp_addsub`

## Requirements
- R1: After reset, `done`, `overflow` and `underflow` are 0, and `result` holds the packed zero pattern: sign 0, exponent digits 00, fraction digits all 0.
- R2: The packed layout is as follows. Bit 40 is the sign, with 1 meaning negative. Bits 39:36 and 35:32 hold the tens and units digits of the biased exponent. Bits 31:0 hold eight fraction digits, with the most significant digit in 31:28. Each digit is its value plus 3.
- R3: For two operands with equal exponents and the same effective sign, the result has that sign and exponent, and its fraction is the decimal sum of the two fractions.
- R4: When the exponents differ, the fraction with the smaller exponent moves right one digit per exponent step until the exponents match. Digits moved past the last position are dropped.
- R5: When the exponent gap is large enough to move every digit out, the smaller operand counts as zero. The result then equals the other operand.
- R6: When the effective signs differ, or when `sub` is 1, the result carries the sign of the operand with the larger magnitude. Its fraction is the magnitude of the difference.
- R7: A sum of 1.0 or more moves the fraction right one digit and raises the exponent by one. The digit moved out is dropped.
- R8: A result whose leading digit is 0 moves left one digit per step, lowering the exponent each time, until its leading digit is nonzero.
- R9: A result whose value is zero is returned as the packed zero pattern, with a positive sign.
- R10: If the exponent would rise above 99, `overflow` pulses with `done` and `result` is the packed zero pattern.
- R11: If the exponent would drop below 00, `underflow` pulses with `done` and `result` is the packed zero pattern. `overflow` and `underflow` are never high together.
- R12: `done` is high for exactly one cycle. It rises 3 + a + n clock edges after the edge that samples `start`, where a is the number of alignment shifts and n is the number of normalization shifts.
- R13: A `start` that arrives while an operation is in progress is ignored. The running operation returns its own result, and only one `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| sub | input | 1 | 1 computes op_a - op_b, 0 computes op_a + op_b |
| op_a | input | 41 | First operand, packed |
| op_b | input | 41 | Second operand, packed |
| result | output | 41 | Packed result, held until the next operation finishes |
| done | output | 1 | One-cycle pulse when result is valid |
| overflow | output | 1 | Exponent exceeded 99 (with done) |
| underflow | output | 1 | Exponent went below 00 (with done) |

## Verification
A carry out of the sum and a rise of the exponent past its limit are decided in the same normalization cycle. The bench provokes this by adding two large fractions whose exponents are both 99. It judges the outcome by seeing `overflow` together with `done` and a packed zero result. Underflow works the same way: a left shift from exponent 00 is requested and judged by the same means. The effective sign is also covered. A subtraction of a negative operand is compared with a plain addition of the same magnitudes.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
    localparam int DIG_W   = 4;
    localparam int XS3_OFF = 3;
    localparam int EXP_TOP = 99;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_ADD   = 2'd2,
        ST_NORM  = 2'd3
    } dfp_state_e;

    function automatic logic [3:0] nine_c(input logic [3:0] d);
        return 4'd9 - d;
    endfunction
endpackage

// File: rtl/dfp_dec_ripple.sv
module dfp_dec_ripple #(
    parameter int N = 9
) (
    input  logic [4*N-1:0] x_i,
    input  logic [4*N-1:0] y_i,
    input  logic           cin_i,
    output logic [4*N-1:0] s_o
);
    logic [N-1:0] c;
    assign c[0] = cin_i;

    for (genvar i = 0; i < N; i++) begin : g_dig
        logic [4:0] raw;
        logic [4:0] adj;
        logic       gt;
        assign raw = {1'b0, x_i[4*i +: 4]} + {1'b0, y_i[4*i +: 4]} + {4'd0, c[i]};
        assign adj = raw - 5'd10;
        assign gt  = (raw > 5'd9);
        assign s_o[4*i +: 4] = gt ? adj[3:0] : raw[3:0];
        if (i < N - 1) begin : g_carry
            assign c[i+1] = gt;
        end
    end
endmodule

// File: rtl/dfp_unpack.sv
module dfp_unpack #(
    parameter int NF = 8
) (
    input  logic [4*(NF+2):0] pk_i,
    output logic              sign_o,
    output logic [6:0]        exp_o,
    output logic [4*NF-1:0]   frac_o
);
    localparam int FW = 4 * NF;

    logic [3:0] e_hi, e_lo;
    assign sign_o = pk_i[FW + 8];
    assign e_hi   = pk_i[FW + 4 +: 4];
    assign e_lo   = pk_i[FW +: 4];
    assign exp_o  = 7'(({3'd0, e_hi} - 7'd3) * 7'd10 + {3'd0, e_lo} - 7'd3);

    for (genvar i = 0; i < NF; i++) begin : g_frac
        assign frac_o[4*i +: 4] = pk_i[4*i +: 4] - 4'd3;
    end
endmodule

// File: rtl/dfp_pack.sv
module dfp_pack #(
    parameter int NF = 8
) (
    input  logic              sign_i,
    input  logic [6:0]        exp_i,
    input  logic [4*NF-1:0]   frac_i,
    output logic [4*(NF+2):0] pk_o
);
    localparam int FW = 4 * NF;

    logic [6:0] hi, lo;
    assign hi = exp_i / 7'd10;
    assign lo = exp_i % 7'd10;
    assign pk_o[FW + 8]     = sign_i;
    assign pk_o[FW + 4 +: 4] = 4'(hi + 7'd3);
    assign pk_o[FW +: 4]     = 4'(lo + 7'd3);

    for (genvar i = 0; i < NF; i++) begin : g_frac
        assign pk_o[4*i +: 4] = frac_i[4*i +: 4] + 4'd3;
    end
endmodule

// File: rtl/dfp_tc_sum.sv
module dfp_tc_sum
    import dfp_pkg::*;
#(
    parameter int NF = 8
) (
    input  logic [4*(NF+1)-1:0] a_mag_i,
    input  logic                a_neg_i,
    input  logic [4*(NF+1)-1:0] b_mag_i,
    input  logic                b_neg_i,
    output logic [4*(NF+1)-1:0] mag_o,
    output logic                neg_o
);
    localparam int ND = NF + 1;
    localparam int MW = 4 * ND;

    logic [MW-1:0] a_nine, b_nine, s_nine;
    logic [MW-1:0] a_tc, b_tc, a_op, b_op, s_raw, s_neg;

    for (genvar i = 0; i < ND; i++) begin : g_nine
        assign a_nine[4*i +: 4] = nine_c(a_mag_i[4*i +: 4]);
        assign b_nine[4*i +: 4] = nine_c(b_mag_i[4*i +: 4]);
        assign s_nine[4*i +: 4] = nine_c(s_raw[4*i +: 4]);
    end

    dfp_dec_ripple #(.N(ND)) u_neg_a (.x_i(a_nine), .y_i('0), .cin_i(1'b1), .s_o(a_tc));
    dfp_dec_ripple #(.N(ND)) u_neg_b (.x_i(b_nine), .y_i('0), .cin_i(1'b1), .s_o(b_tc));

    assign a_op = a_neg_i ? a_tc : a_mag_i;
    assign b_op = b_neg_i ? b_tc : b_mag_i;

    dfp_dec_ripple #(.N(ND)) u_sum   (.x_i(a_op), .y_i(b_op), .cin_i(1'b0), .s_o(s_raw));
    dfp_dec_ripple #(.N(ND)) u_abs   (.x_i(s_nine), .y_i('0), .cin_i(1'b1), .s_o(s_neg));

    assign neg_o = (s_raw[MW-1 -: 4] >= 4'd5);
    assign mag_o = neg_o ? s_neg : s_raw;
endmodule

// File: rtl/dfp_addsub.sv
module dfp_addsub
    import dfp_pkg::*;
#(
    parameter int NF = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sub,
    input  logic [4*(NF+2):0] op_a,
    input  logic [4*(NF+2):0] op_b,
    output logic [4*(NF+2):0] result,
    output logic              done,
    output logic              overflow,
    output logic              underflow
);
    localparam int FW = 4 * NF;
    localparam int MW = 4 * (NF + 1);
    localparam int PW = 4 * (NF + 2) + 1;
    localparam logic [PW-1:0] ZERO_PK = {1'b0, {(NF + 2){4'h3}}};

    typedef logic signed [7:0] exp_t;

    typedef struct packed {
        dfp_state_e    st;
        logic          sa;
        logic          sb;
        exp_t          ea;
        exp_t          eb;
        logic [FW-1:0] fa;
        logic [FW-1:0] fb;
        logic [MW-1:0] mag;
        logic          rs;
        exp_t          re;
        logic [PW-1:0] res;
        logic          done;
        logic          ovf;
        logic          unf;
    } regs_t;

    regs_t q, d;

    logic          ua_s, ub_s;
    logic [6:0]    ua_e, ub_e;
    logic [FW-1:0] ua_f, ub_f;
    logic [MW-1:0] tc_mag;
    logic          tc_neg;
    logic [PW-1:0] pk;

    dfp_unpack #(.NF(NF)) u_unpack_a (.pk_i(op_a), .sign_o(ua_s), .exp_o(ua_e), .frac_o(ua_f));
    dfp_unpack #(.NF(NF)) u_unpack_b (.pk_i(op_b), .sign_o(ub_s), .exp_o(ub_e), .frac_o(ub_f));

    dfp_tc_sum #(.NF(NF)) u_tc (
        .a_mag_i({4'd0, q.fa}), .a_neg_i(q.sa),
        .b_mag_i({4'd0, q.fb}), .b_neg_i(q.sb),
        .mag_o(tc_mag), .neg_o(tc_neg)
    );

    dfp_pack #(.NF(NF)) u_pack (
        .sign_i(q.rs), .exp_i(q.re[6:0]), .frac_i(q.mag[FW-1:0]), .pk_o(pk)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.ovf  = 1'b0;
        d.unf  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.sa = ua_s;
                    d.sb = ub_s ^ sub;
                    d.ea = exp_t'({1'b0, ua_e});
                    d.eb = exp_t'({1'b0, ub_e});
                    d.fa = ua_f;
                    d.fb = ub_f;
                    d.st = ST_ALIGN;
                end
            end
            ST_ALIGN: begin
                if (q.ea == q.eb) begin
                    d.st = ST_ADD;
                end else if (q.ea < q.eb) begin
                    if (q.fa == '0) begin
                        d.ea = q.eb;
                    end else begin
                        d.fa = q.fa >> 4;
                        d.ea = q.ea + 8'sd1;
                    end
                end else begin
                    if (q.fb == '0) begin
                        d.eb = q.ea;
                    end else begin
                        d.fb = q.fb >> 4;
                        d.eb = q.eb + 8'sd1;
                    end
                end
            end
            ST_ADD: begin
                d.mag = tc_mag;
                d.rs  = tc_neg;
                d.re  = q.ea;
                d.st  = ST_NORM;
            end
            ST_NORM: begin
                if (q.mag == '0) begin
                    d.res  = ZERO_PK;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else if (q.mag[MW-1 -: 4] != 4'd0) begin
                    if (q.re == exp_t'(EXP_TOP)) begin
                        d.res  = ZERO_PK;
                        d.ovf  = 1'b1;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.mag = q.mag >> 4;
                        d.re  = q.re + 8'sd1;
                    end
                end else if (q.mag[FW-1 -: 4] == 4'd0) begin
                    if (q.re == 8'sd0) begin
                        d.res  = ZERO_PK;
                        d.unf  = 1'b1;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.mag = q.mag << 4;
                        d.re  = q.re - 8'sd1;
                    end
                end else begin
                    d.res  = pk;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.res <= ZERO_PK;
        end else begin
            q <= d;
        end
    end

    assign result    = q.res;
    assign done      = q.done;
    assign overflow  = q.ovf;
    assign underflow = q.unf;

    // R12: done is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10, R11: flags only accompany done
    a_r10_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow || underflow) |-> done);

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow));

    a_r10_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (result == ZERO_PK));

    // R9: a zero fraction is always in the canonical positive form
    a_r9_zero_form: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[FW-1:0] == ZERO_PK[FW-1:0]) |-> (result == ZERO_PK));

    // R8: nonzero results leave with a nonzero leading digit
    a_r8_normalized: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !overflow && !underflow && result[FW-1:0] != ZERO_PK[FW-1:0])
            |-> (result[FW-1 -: 4] != 4'h3));

    // R4: each alignment step advances the smaller exponent by exactly one
    a_r4_align_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ALIGN && q.ea < q.eb && q.fa != '0) |=> (q.ea == $past(q.ea) + 8'sd1));
endmodule

// File: tb/dfp_addsub_tb.sv
`timescale 1ns/1ps
module dfp_addsub_tb;
    localparam int NF = 8;
    localparam int PW = 4 * (NF + 2) + 1;

    typedef struct packed {
        bit sub; bit as; int ae; int af;
        bit bs; int be; int bf;
        bit rs; int re; int rf; bit ov; bit un;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{0, 0, 50, 12345678, 0, 50, 11111111, 0, 50, 23456789, 0, 0}, // R3
        '{0, 0, 52, 50000000, 0, 50, 12345678, 0, 52, 50123456, 0, 0}, // R4 b shifted, digits dropped
        '{0, 0, 60, 30000000, 0, 50, 99999999, 0, 60, 30000000, 0, 0}, // R5
        '{1, 0, 53, 25500000, 0, 52, 63000000, 0, 53, 19200000, 0, 0}, // R6 and R4
        '{1, 0, 52, 21000000, 0, 52, 34000000, 1, 52, 13000000, 0, 0}, // R6 negative result
        '{0, 1, 50, 50000000, 0, 50, 20000000, 1, 50, 30000000, 0, 0}, // R6 mixed signs
        '{1, 1, 50, 40000000, 1, 50, 10000000, 1, 50, 30000000, 0, 0}, // R6 subtract a negative
        '{0, 0, 50, 60000000, 0, 50, 70000000, 0, 51, 13000000, 0, 0}, // R7
        '{0, 0, 50, 99999999, 0, 50, 10000001, 0, 51, 11000000, 0, 0}, // R7 drop moved-out digit
        '{1, 0, 55, 12345678, 0, 55, 12300000, 0, 52, 45678000, 0, 0}, // R8
        '{1, 0, 40, 55555555, 0, 40, 55555555, 0,  0,        0, 0, 0}, // R9
        '{0, 1, 45, 20000000, 0, 45, 20000000, 0,  0,        0, 0, 0}, // R9 signed cancel
        '{0, 0, 99, 90000000, 0, 99, 20000000, 0,  0,        0, 1, 0}, // R10
        '{1, 0,  0, 10000000, 0,  0,  9000000, 0,  0,        0, 0, 1}, // R11
        '{0, 0, 48, 12345678, 0, 50, 40000000, 0, 50, 40123456, 0, 0}  // R4 a shifted
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sub_i = 1'b0;
    logic [PW-1:0] op_a = '0;
    logic [PW-1:0] op_b = '0;
    logic [PW-1:0] result;
    logic done, overflow, underflow;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dfp_addsub #(.NF(NF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sub(sub_i),
        .op_a(op_a), .op_b(op_b), .result(result),
        .done(done), .overflow(overflow), .underflow(underflow)
    );

    function automatic logic [PW-1:0] enc(input bit s, input int e, input int f);
        logic [PW-1:0] r;
        int v;
        r = '0;
        r[PW-1] = s;
        r[4*NF+4 +: 4] = 4'((e / 10) + 3);
        r[4*NF +: 4]   = 4'((e % 10) + 3);
        v = f;
        for (int i = 0; i < NF; i++) begin
            r[4*i +: 4] = 4'((v % 10) + 3);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [PW-1:0] a, input logic [PW-1:0] b, input bit s,
                          output logic [PW-1:0] res, output bit ov, output bit un,
                          output int cyc);
        @(negedge clk);
        op_a = a; op_b = b; sub_i = s; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        if (!done) check(1'b0, "R12 timeout", '0, '1);
        res = result; ov = overflow; un = underflow;
    endtask

    initial begin : watchdog
        #500us;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [PW-1:0] res;
        bit ov, un;
        int cyc;
        int extra;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(result == enc(0, 0, 0), "R1 result", result, enc(0, 0, 0));
        check(done == 1'b0 && overflow == 1'b0 && underflow == 1'b0, "R1 flags",
              {done, overflow, underflow}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(enc(VEC[i].as, VEC[i].ae, VEC[i].af),
                   enc(VEC[i].bs, VEC[i].be, VEC[i].bf), VEC[i].sub, res, ov, un, cyc);
            check(res == enc(VEC[i].rs, VEC[i].re, VEC[i].rf), "R2 vector result",
                  res, enc(VEC[i].rs, VEC[i].re, VEC[i].rf));
            check(ov == VEC[i].ov && un == VEC[i].un, "R10 R11 vector flags",
                  {ov, un}, {VEC[i].ov, VEC[i].un});
        end

        // R12 latency: two alignment shifts, no normalization
        run_op(enc(0, 52, 50000000), enc(0, 50, 12345678), 1'b0, res, ov, un, cyc);
        check(cyc == 5, "R12 latency align", PW'(cyc), PW'(5));
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R12 single pulse", PW'(done), '0);

        // R12 latency: three normalization shifts
        run_op(enc(0, 55, 12345678), enc(0, 55, 12300000), 1'b1, res, ov, un, cyc);
        check(cyc == 6, "R12 latency normalize", PW'(cyc), PW'(6));

        // R10 and R7 in the same cycle; flag drops after the pulse
        run_op(enc(0, 99, 99999999), enc(0, 99, 99999999), 1'b0, res, ov, un, cyc);
        check(ov == 1'b1 && res == enc(0, 0, 0), "R10 carry at top exponent",
              {ov, res}, {1'b1, enc(0, 0, 0)});
        @(posedge clk);
        @(negedge clk);
        check(overflow == 1'b0, "R10 flag pulse", PW'(overflow), '0);

        // R13 start while busy is ignored
        @(negedge clk);
        op_a = enc(0, 60, 30000000); op_b = enc(0, 50, 99999999); sub_i = 1'b0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op_a = enc(1, 20, 11111111); op_b = enc(1, 20, 11111111); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        check(result == enc(0, 60, 30000000), "R13 busy start ignored", result,
              enc(0, 60, 30000000));
        extra = 0;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) extra++;
        end
        check(extra == 0, "R13 single done", PW'(extra), '0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule